// File: doc/BRIEF.md
# Dual-Comparator Timer with Waveform Output

This block is a 10-bit up-counter with two compare registers, A and P, that drives one output pin. The counter advances on each cycle where the clock-enable input is high and the run bit is set. While the run bit is low, the counter is held at zero. The pin works in one of three modes:

- **Compare mode:** a match on comparator A can leave the pin alone, force it low, force it high, or toggle it.
- **PWM mode:** the pin carries a pulse-width-modulated waveform. A select bit decides which comparator sets the period and which sets the duty.
- **Counter mode:** the pin stays low, and the block is just a counter with match flags.

A final inversion stage can flip the pin in compare and PWM modes.

In compare and counter modes, the counter wraps on one of two events:

- **A match:** the counter is cleared when it matches comparator A.
- **P match:** the counter is cleared when it matches comparator P. If P is zero, the counter instead runs to its maximum value and overflows to zero.

The action code and the role-swap bit are captured while the timer is stopped and held for the whole run. Changing them mid-run cannot disturb the waveform.

Top module: `dualCmpTimer`

## Requirements
- R1: While `timerOn` is low, the counter is held at 0. While `timerOn` is high, the counter increments by one on each clock edge where `tickEn` is high, and holds on edges where `tickEn` is low.
- R2: Mode select `modeSel` encodes: 00 counter mode, 01 compare mode, 10 PWM mode, 11 counter mode. In compare mode, `outCtl` gives the pin level before any match: 0 is low, 1 is high.
- R3: In compare mode, on an edge where `tickEn` is high and the counter equals `cmpA`, action code `actSel` is applied to the pin. The codes are: 00 no change, 01 drive low, 10 drive high, 11 toggle. An action equal to the present level gives no visible change.
- R4: After the pin has changed, stopping the timer and starting it again (a rise of `timerOn`) restores the pin to the level given by `outCtl`.
- R5: In PWM mode with `dutySwap` = 0, `cmpP` is the period in ticks and `cmpA` is the duty in ticks. The pin is at its active level while the counter is below the duty and inactive otherwise. `outCtl` = 1 means active high and 0 means active low. While stopped, the pin is inactive.
- R6: In PWM mode with `dutySwap` = 1, `cmpA` is the period and `cmpP` is the duty.
- R7: In PWM mode, a duty at or above a nonzero period keeps the pin always active. A period value of 0 gives a full 1024-tick period.
- R8: `polInv` = 1 inverts the pin in compare and PWM modes. In counter mode the pin is always 0, whatever `outCtl` and `polInv` are.
- R9: Outside PWM mode with `clrSelA` = 1, a tick while the counter equals `cmpA` sets the counter to 0.
- R10: Outside PWM mode with `clrSelA` = 0, a tick while the counter equals a nonzero `cmpP` sets the counter to 0. If `cmpP` is 0, the counter runs to 1023 and then wraps to 0.
- R11: In PWM mode, `clrSelA` has no effect. Only the period ends a cycle.
- R12: `actSel` and `dutySwap` are sampled while `timerOn` is low and held while it is high. Changes made during a run have no effect until the next start.
- R13: `matchA` is high exactly when `timerOn` is high and the counter equals `cmpA`. `matchP` is high exactly when `timerOn` is high and the counter equals `cmpP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Count enable |
| timerOn | input | 1 | Run bit; low holds counter at zero |
| modeSel | input | 2 | Mode: 00/11 counter, 01 compare, 10 PWM |
| actSel | input | 2 | Compare action: none/low/high/toggle |
| outCtl | input | 1 | Initial level (compare) or active level (PWM) |
| polInv | input | 1 | Invert output pin |
| dutySwap | input | 1 | Swap period/duty roles of A and P |
| clrSelA | input | 1 | Counter clear source: 1 = A, 0 = P/overflow |
| cmpA | input | 10 | Comparator A value |
| cmpP | input | 10 | Comparator P value |
| pinOut | output | 1 | Timer output pin |
| matchA | output | 1 | Counter equals A while running |
| matchP | output | 1 | Counter equals P while running |

## Verification
The pin and both match flags are combinational functions of the counter and the pin register. A tick or compare action sampled at rising edge k therefore shows up on the outputs just after edge k, and a rise of `timerOn` takes effect one edge later. The bench drives every input at the falling edge and compares the outputs one time unit afterwards. It then advances its own model by exactly one rising edge using the inputs that stay stable across that edge. This keeps the expected values aligned to the same edge the design registers on.

// File: rtl/tmrPkg.sv
package tmrPkg;
  typedef enum logic [1:0] {
    MODE_COUNT = 2'b00,
    MODE_CMP   = 2'b01,
    MODE_PWM   = 2'b10,
    MODE_SPARE = 2'b11
  } tmrMode_e;

  localparam logic [1:0] ACT_NONE = 2'b00;
  localparam logic [1:0] ACT_LOW  = 2'b01;
  localparam logic [1:0] ACT_HIGH = 2'b10;
  localparam logic [1:0] ACT_TOG  = 2'b11;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic hold0;  // force counter to zero
    logic step;   // advance this edge
    logic wipe;   // the advance becomes a clear
  } tmrStrb_t;
endpackage

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import tmrPkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrb_t     strb,
  input  logic [W-1:0] cmpA,
  input  logic [W-1:0] cmpP,
  output logic [W-1:0] cnt,
  output logic         eqA,
  output logic         eqP
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (strb.hold0) cnt <= '0;
    else if (strb.step)  cnt <= strb.wipe ? '0 : cnt + W'(1);
  end

  assign eqA = (cnt == cmpA);
  assign eqP = (cnt == cmpP);
endmodule

// File: rtl/tmrControl.sv
module tmrControl
  import tmrPkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         timerOn,
  input  logic         tickEn,
  input  logic [1:0]   modeSel,
  input  logic [1:0]   actSel,
  input  logic         outCtl,
  input  logic         polInv,
  input  logic         dutySwap,
  input  logic         clrSelA,
  input  logic [W-1:0] cmpA,
  input  logic [W-1:0] cmpP,
  input  logic [W-1:0] cnt,
  input  logic         eqA,
  input  logic         eqP,
  output tmrStrb_t     strb,
  output logic         pinOut
);
  tmrMode_e     mode;
  logic [1:0]   actLat;
  logic         swapLat;
  logic         pinState;
  logic [W-1:0] periodVal;
  logic [W-1:0] dutyVal;
  logic         periodEnd;
  logic         clrHit;
  logic         pwmActive;

  assign mode      = tmrMode_e'(modeSel);
  assign periodVal = swapLat ? cmpA : cmpP;
  assign dutyVal   = swapLat ? cmpP : cmpA;
  assign periodEnd = (periodVal != '0) && (cnt == periodVal - W'(1));
  assign pwmActive = timerOn && (cnt < dutyVal);

  always_comb begin
    if (mode == MODE_PWM) clrHit = periodEnd;
    else if (clrSelA)     clrHit = eqA;
    else                  clrHit = eqP && (cmpP != '0);
  end

  assign strb.hold0 = !timerOn;
  assign strb.step  = timerOn && tickEn;
  assign strb.wipe  = clrHit;

  // shadow copies follow the fields while stopped, freeze while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actLat  <= ACT_NONE;
      swapLat <= 1'b0;
    end else if (!timerOn) begin
      actLat  <= actSel;
      swapLat <= dutySwap;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinState <= 1'b0;
    else if (!timerOn) pinState <= outCtl;
    else if (tickEn && eqA && mode == MODE_CMP) begin
      case (actLat)
        ACT_LOW:  pinState <= 1'b0;
        ACT_HIGH: pinState <= 1'b1;
        ACT_TOG:  pinState <= ~pinState;
        default:  pinState <= pinState;
      endcase
    end
  end

  always_comb begin
    case (mode)
      MODE_CMP: pinOut = pinState ^ polInv;
      MODE_PWM: pinOut = (pwmActive ? outCtl : ~outCtl) ^ polInv;
      default:  pinOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/dualCmpTimer.sv
module dualCmpTimer
  import tmrPkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         timerOn,
  input  logic [1:0]   modeSel,
  input  logic [1:0]   actSel,
  input  logic         outCtl,
  input  logic         polInv,
  input  logic         dutySwap,
  input  logic         clrSelA,
  input  logic [W-1:0] cmpA,
  input  logic [W-1:0] cmpP,
  output logic         pinOut,
  output logic         matchA,
  output logic         matchP
);
  tmrStrb_t     strb;
  logic [W-1:0] cnt;
  logic         eqA;
  logic         eqP;

  tmrDatapath #(.W(W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpA(cmpA), .cmpP(cmpP),
    .cnt(cnt), .eqA(eqA), .eqP(eqP)
  );

  tmrControl #(.W(W)) uCtl (
    .clk(clk), .rstN(rstN), .timerOn(timerOn), .tickEn(tickEn),
    .modeSel(modeSel), .actSel(actSel), .outCtl(outCtl), .polInv(polInv),
    .dutySwap(dutySwap), .clrSelA(clrSelA), .cmpA(cmpA), .cmpP(cmpP),
    .cnt(cnt), .eqA(eqA), .eqP(eqP), .strb(strb), .pinOut(pinOut)
  );

  assign matchA = timerOn && eqA;
  assign matchP = timerOn && eqP;
endmodule

// File: rtl/tmrChecker.sv
module tmrChecker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rstN,
  input logic         timerOn,
  input logic         tickEn,
  input logic [1:0]   modeSel,
  input logic         outCtl,
  input logic         polInv,
  input logic         clrSelA,
  input logic [W-1:0] cmpA,
  input logic [W-1:0] cmpP,
  input logic [W-1:0] cnt,
  input logic         matchA,
  input logic         pinOut
);
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !timerOn |=> (cnt == '0));

  assert_hold_no_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (timerOn && !tickEn) |=> $stable(cnt));

  assert_restart_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!timerOn && modeSel == 2'b01) ##1 (modeSel == 2'b01 && $stable(outCtl) && $stable(polInv))
    |-> (pinOut == (outCtl ^ polInv)));

  assert_counter_pin_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 || modeSel == 2'b11) |-> !pinOut);

  assert_clear_on_a_R9: assert property (@(posedge clk) disable iff (!rstN)
    (timerOn && tickEn && clrSelA && modeSel != 2'b10 && matchA) |=> (cnt == '0));

  assert_full_duty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && timerOn && cmpA == cmpP && cmpP != '0 && cnt < cmpP)
    |-> (pinOut == (outCtl ^ polInv)));

  assert_match_needs_run_R13: assert property (@(posedge clk) disable iff (!rstN)
    matchA |-> timerOn);
endmodule

bind dualCmpTimer tmrChecker #(.W(W)) uChk (
  .clk(clk), .rstN(rstN), .timerOn(timerOn), .tickEn(tickEn),
  .modeSel(modeSel), .outCtl(outCtl), .polInv(polInv), .clrSelA(clrSelA),
  .cmpA(cmpA), .cmpP(cmpP), .cnt(cnt), .matchA(matchA), .pinOut(pinOut)
);

// File: tb/tb_dualCmpTimer.sv
module tb_dualCmpTimer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rstN, tickEn, timerOn, outCtl, polInv, dutySwap, clrSelA;
  logic [1:0] modeSel, actSel;
  logic [W-1:0] cmpA, cmpP;
  logic pinOut, matchA, matchP;

  dualCmpTimer #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .timerOn(timerOn),
    .modeSel(modeSel), .actSel(actSel), .outCtl(outCtl), .polInv(polInv),
    .dutySwap(dutySwap), .clrSelA(clrSelA), .cmpA(cmpA), .cmpP(cmpP),
    .pinOut(pinOut), .matchA(matchA), .matchP(matchP)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit rndTick = 0;
  string tag = "R1";

  // bench model state
  logic [W-1:0] mCnt;
  logic mPin, mSwap;
  logic [1:0] mAct;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic expPin();
    logic [W-1:0] per, duty;
    logic act;
    per  = mSwap ? cmpA : cmpP;
    duty = mSwap ? cmpP : cmpA;
    case (modeSel)
      2'b01: return mPin ^ polInv;
      2'b10: begin
        act = timerOn && (mCnt < duty);
        return (act ? outCtl : ~outCtl) ^ polInv;
      end
      default: return 1'b0;
    endcase
  endfunction

  task automatic stepModel();
    logic [W-1:0] per;
    logic clr;
    if (!timerOn) begin
      mCnt = '0; mPin = outCtl; mAct = actSel; mSwap = dutySwap;
    end else if (tickEn) begin
      if (modeSel == 2'b01 && mCnt == cmpA) begin
        case (mAct)
          2'b01: mPin = 1'b0;
          2'b10: mPin = 1'b1;
          2'b11: mPin = ~mPin;
          default: ;
        endcase
      end
      per = mSwap ? cmpA : cmpP;
      if (modeSel == 2'b10) clr = (per != '0) && (mCnt == per - W'(1));
      else if (clrSelA)     clr = (mCnt == cmpA);
      else                  clr = (cmpP != '0) && (mCnt == cmpP);
      mCnt = clr ? '0 : mCnt + W'(1);
    end
  endtask

  task automatic cycle();
    if (rndTick) tickEn = ($urandom % 4) != 0;
    #1;
    chk("pinOut", int'(pinOut), int'(expPin()));
    chk("matchA R13", int'(matchA), int'(timerOn && mCnt == cmpA));
    chk("matchP R13", int'(matchP), int'(timerOn && mCnt == cmpP));
    stepModel();
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic setup(input logic [1:0] md, input logic [1:0] act, input logic oc,
                       input logic pol, input logic sw, input logic csa,
                       input int a, input int p);
    timerOn = 1'b0;
    modeSel = md; actSel = act; outCtl = oc; polInv = pol;
    dutySwap = sw; clrSelA = csa; cmpA = W'(a); cmpP = W'(p);
    run(2);
    timerOn = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; tickEn = 1'b0; timerOn = 1'b0; modeSel = 2'b01; actSel = 2'b00;
    outCtl = 1'b0; polInv = 1'b0; dutySwap = 1'b0; clrSelA = 1'b0;
    cmpA = '0; cmpP = '0;
    mCnt = '0; mPin = 1'b0; mSwap = 1'b0; mAct = 2'b00;
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    chk("pinOut", int'(pinOut), 0);
    chk("matchA", int'(matchA), 0);
    rstN = 1'b1;
    @(negedge clk);
    stepModel();

    // R1 R13: counting with gaps, P clears at 8
    tag = "R1 R13"; rndTick = 1; tickEn = 1'b1;
    setup(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 5, 8); run(40);
    // R2 R3: drive high from initial low
    tag = "R2 R3 high"; setup(2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 3, 10); run(30);
    tag = "R3 low";     setup(2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 3, 10); run(30);
    tag = "R3 same";    setup(2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 3, 10); run(30);
    tag = "R3 R9 toggle"; setup(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 4, 20); run(40);
    // R4: stop one cycle and restart
    tag = "R4 restart"; timerOn = 1'b0; cycle(); timerOn = 1'b1; run(12);
    // R5 PWM, both active levels
    tag = "R5 pwm hi"; setup(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 3, 8); run(40);
    tag = "R5 pwm lo"; setup(2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3, 8); run(40);
    tag = "R6 swap";   setup(2'b10, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8, 3); run(40);
    tag = "R7 full";   setup(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 9, 6); run(30);
    tag = "R8 invert cmp"; setup(2'b01, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 2, 6); run(30);
    tag = "R8 invert pwm"; setup(2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 2, 6); run(30);
    tag = "R8 counter";    setup(2'b00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 2, 6); run(30);
    tag = "R11 pwm ignore clr"; setup(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 2, 7); run(40);
    // R12: change latched fields mid-run
    tag = "R12 frozen act"; setup(2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 2, 5); run(3);
    actSel = 2'b11; run(30);
    tag = "R12 frozen swap"; setup(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 2, 9); run(5);
    dutySwap = 1'b1; run(30);
    // R7 R10: long wraps with tick always on
    rndTick = 0; tickEn = 1'b1;
    tag = "R7 period zero"; setup(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 5, 0); run(1100);
    tag = "R10 overflow";   setup(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1023, 0); run(1100);
    tag = "R10 clear on P"; setup(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 2, 6); run(30);

    // random rounds
    rndTick = 1;
    for (int r = 0; r < 80; r++) begin
      logic [1:0] md;
      md = 2'($urandom % 4);
      tag = (md == 2'b01) ? "R3 R12 rand cmp" : (md == 2'b10) ? "R5 R6 rand pwm" : "R8 R10 rand cnt";
      setup(md, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            int'($urandom % 16), int'($urandom % 16));
      for (int c = 0; c < 10 + int'($urandom % 50); c++) begin
        if ($urandom % 16 == 0) begin
          actSel = 2'($urandom); dutySwap = 1'($urandom); clrSelA = 1'($urandom);
          outCtl = 1'($urandom); polInv = 1'($urandom);
        end
        cycle();
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule